// File: doc/BRIEF.md
# DMA Channel Address and Count Sequencer

This block keeps the per-channel transfer state of one DMA channel. Software-side logic loads it in one cycle with a 16-bit start offset, a page value, a 16-bit count and three mode flags. The count is the number of transfers minus one. Each accepted transfer acknowledge produces one bus address on an output stream. The acknowledge also steps the offset up or down and decrements the count. When the count runs out, the block flags the final transfer. It then either masks the channel or reloads itself from base copies made at load time.

The channel has two widths. A byte-wide channel forms a 20-bit address from its offset and the low four bits of its page. A word-wide channel forms a 24-bit byte address. The offset is shifted left by one into bits 16:1 and bit 0 is zero, while page bits 7:1 pass through unshifted into bits 23:17. The offset counter wraps within 16 bits and never carries into the page.

The acknowledge input and the address output are valid/ready pairs. An acknowledge is taken only when `ack_valid` and `ack_ready` are both high. `ack_ready` is low in three cases: while the channel is masked, during a load cycle, and while an address is waiting on a stalled output. An address held with `xfer_valid` high and `xfer_ready` low stays unchanged until it is taken.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset the channel is masked (`chan_masked`=1), `chan_done`=0, `xfer_valid`=0 and `ack_ready`=0.
- R2: A cycle with `cfg_load`=1 stores offset, page, count and mode as both base and current values, clears the mask and the done flag, and the first accepted acknowledge after it outputs the address formed from the loaded offset.
- R3: A loaded count of N yields exactly N+1 transfers; `xfer_last` is 1 on the transfer taken while the current count is 0, and 0 on all others.
- R4: With `cfg_dec`=1 the offset falls by one after each transfer, otherwise it rises by one; it wraps between FFFFh and 0000h without changing the page bits of the address.
- R5: With `cfg_word`=0 the address is {4'b0, page[3:0], offset}.
- R6: With `cfg_word`=1 the address is {page[7:1], offset, 1'b0}.
- R7: With `cfg_auto`=0, the final transfer sets `chan_masked`. While masked, `ack_ready` is 0 and acknowledges have no effect until the next load.
- R8: With `cfg_auto`=1, the final transfer reloads offset and count from their base copies, the channel stays unmasked, and the address sequence repeats.
- R9: `chan_done` becomes 1 with the final transfer and stays 1 until the next load.
- R10: The output follows valid/ready. An acknowledge taken at a clock edge shows `xfer_valid`=1 with its address after that edge. A held address stays stable while `xfer_ready`=0. `ack_ready` is 0 while an address is waiting and `xfer_ready`=0.
- R11: When `cfg_load` and `ack_valid` are high in the same cycle, the load takes effect and the acknowledge is not accepted (`ack_ready`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Load strobe for all cfg_* values |
| cfg_offset | input | 16 | Start offset |
| cfg_page | input | 8 | Page value |
| cfg_count | input | 16 | Number of transfers minus one |
| cfg_dec | input | 1 | 1: offset steps down |
| cfg_auto | input | 1 | 1: reload from base at the final transfer |
| cfg_word | input | 1 | 1: word-wide address forming |
| ack_valid | input | 1 | Transfer acknowledge offered |
| ack_ready | output | 1 | Acknowledge can be taken this cycle |
| xfer_valid | output | 1 | Bus address available |
| xfer_ready | input | 1 | Downstream takes the address |
| xfer_addr | output | 24 | Bus byte address of the transfer |
| xfer_last | output | 1 | This transfer is the final one of the count |
| chan_masked | output | 1 | Channel is masked |
| chan_done | output | 1 | Completion status |

## Verification
Every result appears one clock after the edge that takes its acknowledge or load. The address, last flag, mask and done flag come out of registers. The bench therefore keeps a reference state that it advances once per edge, and compares each output against it at the next falling edge. `ack_ready` is combinational from the current inputs, so the bench checks it a short delay after driving the inputs in the same cycle. Stalls on `xfer_ready` are checked in every cycle they last. Directed sequences add literal expected addresses for the wrap and load cases, and a count of completed handshakes for the transfer total.

// File: rtl/dma_seq_pkg.sv
`timescale 1ns/1ps
package dma_seq_pkg;

  typedef struct packed {
    logic dec;
    logic autoinit;
    logic word;
  } chan_mode_t;

  typedef enum logic [1:0] {
    STEP_HOLD   = 2'd0,
    STEP_NEXT   = 2'd1,
    STEP_RELOAD = 2'd2
  } step_op_e;

endpackage

// File: rtl/dma_seq_addr_ctr.sv
`timescale 1ns/1ps
module dma_seq_addr_ctr
  import dma_seq_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  step_op_e     op,
  input  logic         dec,
  output logic [W-1:0] cur
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] base_q;
  logic [W-1:0] cur_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      cur_q  <= '0;
    end else if (load) begin
      base_q <= load_val;
      cur_q  <= load_val;
    end else begin
      case (op)
        STEP_NEXT:   cur_q <= dec ? (cur_q - ONE) : (cur_q + ONE);
        STEP_RELOAD: cur_q <= base_q;
        default:     cur_q <= cur_q;
      endcase
    end
  end

  assign cur = cur_q;
endmodule

// File: rtl/dma_seq_cnt_ctr.sv
`timescale 1ns/1ps
module dma_seq_cnt_ctr
  import dma_seq_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  step_op_e     op,
  output logic         at_zero
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] base_q;
  logic [W-1:0] cur_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      cur_q  <= '0;
    end else if (load) begin
      base_q <= load_val;
      cur_q  <= load_val;
    end else begin
      case (op)
        STEP_NEXT:   cur_q <= cur_q - ONE;
        STEP_RELOAD: cur_q <= base_q;
        default:     cur_q <= cur_q;
      endcase
    end
  end

  assign at_zero = (cur_q == '0);
endmodule

// File: rtl/dma_seq_fmt.sv
`timescale 1ns/1ps
module dma_seq_fmt #(
  parameter int ADDR_W      = 16,
  parameter int PAGE_W      = 8,
  parameter int BYTE_PAGE_W = 4,
  localparam int BUS_W      = ADDR_W + PAGE_W
) (
  input  logic              word,
  input  logic [PAGE_W-1:0] page,
  input  logic [ADDR_W-1:0] offset,
  output logic [BUS_W-1:0]  bus_addr
);
  localparam int BYTE_W = ADDR_W + BYTE_PAGE_W;

  logic [BUS_W-1:0] byte_addr;
  logic [BUS_W-1:0] word_addr;

  generate
    if (BUS_W > BYTE_W) begin : g_pad
      assign byte_addr = {{(BUS_W - BYTE_W){1'b0}}, page[BYTE_PAGE_W-1:0], offset};
    end else begin : g_nopad
      assign byte_addr = {page[BYTE_PAGE_W-1:0], offset};
    end
  endgenerate

  assign word_addr = {page[PAGE_W-1:1], offset, 1'b0};
  assign bus_addr  = word ? word_addr : byte_addr;
endmodule

// File: rtl/dma_seq_out_stage.sv
`timescale 1ns/1ps
module dma_seq_out_stage #(
  parameter int BUS_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [BUS_W-1:0] push_addr,
  input  logic             push_last,
  input  logic             ready,
  output logic             valid,
  output logic [BUS_W-1:0] addr,
  output logic             last,
  output logic             can_take
);
  logic             valid_q;
  logic [BUS_W-1:0] addr_q;
  logic             last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      last_q  <= 1'b0;
    end else if (push) begin
      valid_q <= 1'b1;
      addr_q  <= push_addr;
      last_q  <= push_last;
    end else if (ready) begin
      valid_q <= 1'b0;
    end
  end

  assign can_take = !valid_q || ready;
  assign valid    = valid_q;
  assign addr     = addr_q;
  assign last     = last_q;
endmodule

// File: rtl/dma_chan_seq.sv
`timescale 1ns/1ps
module dma_chan_seq
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int PAGE_W      = 8,
  parameter int CNT_W       = 16,
  parameter int BYTE_PAGE_W = 4,
  localparam int BUS_W      = ADDR_W + PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [ADDR_W-1:0] cfg_offset,
  input  logic [PAGE_W-1:0] cfg_page,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic              cfg_dec,
  input  logic              cfg_auto,
  input  logic              cfg_word,
  input  logic              ack_valid,
  output logic              ack_ready,
  output logic              xfer_valid,
  input  logic              xfer_ready,
  output logic [BUS_W-1:0]  xfer_addr,
  output logic              xfer_last,
  output logic              chan_masked,
  output logic              chan_done
);
  chan_mode_t        mode_q;
  logic [PAGE_W-1:0] page_q;
  logic              masked_q;
  logic              done_q;
  logic              word_q;
  logic              auto_q;

  logic              stage_can_take;
  logic              accept;
  logic              cnt_zero;
  step_op_e          op;
  logic [ADDR_W-1:0] cur_offset;
  logic [BUS_W-1:0]  formed_addr;

  assign word_q    = mode_q.word;
  assign auto_q    = mode_q.autoinit;
  assign ack_ready = !masked_q && !cfg_load && stage_can_take;
  assign accept    = ack_valid && ack_ready;

  always_comb begin
    if (!accept)                 op = STEP_HOLD;
    else if (cnt_zero && auto_q) op = STEP_RELOAD;
    else                         op = STEP_NEXT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= '0;
      page_q   <= '0;
      masked_q <= 1'b1;
      done_q   <= 1'b0;
    end else if (cfg_load) begin
      mode_q   <= '{dec: cfg_dec, autoinit: cfg_auto, word: cfg_word};
      page_q   <= cfg_page;
      masked_q <= 1'b0;
      done_q   <= 1'b0;
    end else if (accept && cnt_zero) begin
      done_q <= 1'b1;
      if (!auto_q) masked_q <= 1'b1;
    end
  end

  dma_seq_addr_ctr #(.W(ADDR_W)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cfg_load),
    .load_val (cfg_offset),
    .op       (op),
    .dec      (mode_q.dec),
    .cur      (cur_offset)
  );

  dma_seq_cnt_ctr #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cfg_load),
    .load_val (cfg_count),
    .op       (op),
    .at_zero  (cnt_zero)
  );

  dma_seq_fmt #(
    .ADDR_W      (ADDR_W),
    .PAGE_W      (PAGE_W),
    .BYTE_PAGE_W (BYTE_PAGE_W)
  ) u_fmt (
    .word     (word_q),
    .page     (page_q),
    .offset   (cur_offset),
    .bus_addr (formed_addr)
  );

  dma_seq_out_stage #(.BUS_W(BUS_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (accept),
    .push_addr (formed_addr),
    .push_last (cnt_zero),
    .ready     (xfer_ready),
    .valid     (xfer_valid),
    .addr      (xfer_addr),
    .last      (xfer_last),
    .can_take  (stage_can_take)
  );

  assign chan_masked = masked_q;
  assign chan_done   = done_q;
endmodule

// File: rtl/dma_chan_seq_chk.sv
`timescale 1ns/1ps
module dma_chan_seq_chk #(
  parameter int ADDR_W      = 16,
  parameter int PAGE_W      = 8,
  parameter int BYTE_PAGE_W = 4,
  localparam int BUS_W      = ADDR_W + PAGE_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_load,
  input logic             ack_valid,
  input logic             ack_ready,
  input logic             xfer_valid,
  input logic             xfer_ready,
  input logic [BUS_W-1:0] xfer_addr,
  input logic             xfer_last,
  input logic             chan_masked,
  input logic             chan_done,
  input logic             word_q,
  input logic             auto_q
);
  localparam int BYTE_W = ADDR_W + BYTE_PAGE_W;

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid && !xfer_ready |=> xfer_valid && $stable(xfer_addr) && $stable(xfer_last));

  assert_push_visible_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid && ack_ready |=> xfer_valid);

  assert_masked_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    chan_masked |-> !ack_ready);

  assert_load_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |-> !ack_ready);

  assert_last_masks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid && ack_ready && !auto_q |=> (xfer_last == chan_masked));

  assert_auto_unmasked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid && ack_ready && auto_q |=> !chan_masked);

  assert_last_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid && ack_ready |=> (!xfer_last || chan_done));

  assert_word_even_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid && ack_ready && word_q |=> (xfer_addr[0] == 1'b0));

  assert_byte_span_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid && ack_ready && !word_q |=> ((xfer_addr >> BYTE_W) == '0));
endmodule

bind dma_chan_seq dma_chan_seq_chk #(
  .ADDR_W      (ADDR_W),
  .PAGE_W      (PAGE_W),
  .BYTE_PAGE_W (BYTE_PAGE_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_load    (cfg_load),
  .ack_valid   (ack_valid),
  .ack_ready   (ack_ready),
  .xfer_valid  (xfer_valid),
  .xfer_ready  (xfer_ready),
  .xfer_addr   (xfer_addr),
  .xfer_last   (xfer_last),
  .chan_masked (chan_masked),
  .chan_done   (chan_done),
  .word_q      (word_q),
  .auto_q      (auto_q)
);

// File: tb/dma_chan_seq_test.sv
`timescale 1ns/1ps
module dma_chan_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_load = 1'b0;
  logic [15:0] cfg_offset = '0;
  logic [7:0]  cfg_page = '0;
  logic [15:0] cfg_count = '0;
  logic        cfg_dec = 1'b0, cfg_auto = 1'b0, cfg_word = 1'b0;
  logic        ack_valid = 1'b0;
  logic        ack_ready;
  logic        xfer_valid;
  logic        xfer_ready = 1'b1;
  logic [23:0] xfer_addr;
  logic        xfer_last;
  logic        chan_masked;
  logic        chan_done;

  int vectors = 0;
  int misses = 0;
  int handshakes = 0;
  bit finished = 1'b0;

  // reference state
  logic        m_ov = 0, m_last = 0, m_masked = 1, m_done = 0, m_pword = 0;
  logic [23:0] m_addr = '0;
  logic [15:0] m_cur = '0, m_cnt = '0, m_bcur = '0, m_bcnt = '0;
  logic [7:0]  m_page = '0;
  logic        m_dec = 0, m_auto = 0, m_word = 0;

  always #2.5 clk = ~clk;

  dma_chan_seq uut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_offset(cfg_offset),
    .cfg_page(cfg_page), .cfg_count(cfg_count), .cfg_dec(cfg_dec),
    .cfg_auto(cfg_auto), .cfg_word(cfg_word), .ack_valid(ack_valid),
    .ack_ready(ack_ready), .xfer_valid(xfer_valid), .xfer_ready(xfer_ready),
    .xfer_addr(xfer_addr), .xfer_last(xfer_last), .chan_masked(chan_masked),
    .chan_done(chan_done)
  );

  function automatic logic [23:0] form_addr(logic word, logic [7:0] page, logic [15:0] off);
    if (word) return {page[7:1], 17'(off) << 1};
    return {4'h0, page[3:0], off};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic set_cfg(logic [15:0] off, logic [7:0] pg, logic [15:0] cnt,
                         logic dec, logic au, logic wd);
    cfg_offset = off; cfg_page = pg; cfg_count = cnt;
    cfg_dec = dec; cfg_auto = au; cfg_word = wd;
  endtask

  // called just after a falling edge; returns just after the next one
  task automatic step(logic ld, logic av, logic rd);
    logic exp_rdy;
    check("R10 xfer_valid", 32'(xfer_valid), 32'(m_ov));
    if (m_ov) begin
      check(m_pword ? "R6 xfer_addr" : "R5 xfer_addr", 32'(xfer_addr), 32'(m_addr));
      check("R3 xfer_last", 32'(xfer_last), 32'(m_last));
    end
    check("R7 chan_masked", 32'(chan_masked), 32'(m_masked));
    check("R9 chan_done", 32'(chan_done), 32'(m_done));
    cfg_load = ld; ack_valid = av; xfer_ready = rd;
    #1;
    exp_rdy = !m_masked && !ld && (!m_ov || rd);
    check(ld ? "R11 ack_ready" : "R10 ack_ready", 32'(ack_ready), 32'(exp_rdy));
    if (xfer_valid && rd) handshakes++;
    if (m_ov && rd) m_ov = 1'b0;
    if (ld) begin
      m_cur = cfg_offset; m_bcur = cfg_offset; m_cnt = cfg_count; m_bcnt = cfg_count;
      m_page = cfg_page; m_dec = cfg_dec; m_auto = cfg_auto; m_word = cfg_word;
      m_masked = 1'b0; m_done = 1'b0;
    end else if (av && exp_rdy) begin
      m_ov = 1'b1; m_addr = form_addr(m_word, m_page, m_cur);
      m_last = (m_cnt == 16'h0); m_pword = m_word;
      if (m_cnt == 16'h0) begin
        m_done = 1'b1;
        if (m_auto) begin
          m_cur = m_bcur; m_cnt = m_bcnt;
        end else begin
          m_cur = m_dec ? m_cur - 16'h1 : m_cur + 16'h1;
          m_cnt = 16'hFFFF; m_masked = 1'b1;
        end
      end else begin
        m_cur = m_dec ? m_cur - 16'h1 : m_cur + 16'h1;
        m_cnt = m_cnt - 16'h1;
      end
    end
    @(negedge clk);
    cfg_load = 1'b0; ack_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      misses++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4711);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    ack_valid = 1'b1;
    #1;
    // R1 reset state
    check("R1 chan_masked", 32'(chan_masked), 32'd1);
    check("R1 chan_done", 32'(chan_done), 32'd0);
    check("R1 xfer_valid", 32'(xfer_valid), 32'd0);
    check("R1 ack_ready", 32'(ack_ready), 32'd0);
    @(negedge clk);
    ack_valid = 1'b0;

    // R2/R3/R7: byte channel, count 2 -> three transfers, then masked
    set_cfg(16'h1234, 8'h5A, 16'd2, 1'b0, 1'b0, 1'b0);
    step(1, 0, 1);
    handshakes = 0;
    step(0, 1, 1);
    check("R2 first address", 32'(xfer_addr), 32'h0A1234);
    step(0, 1, 1);
    step(0, 1, 1);
    step(0, 1, 1);   // R7: ignored, channel masked
    step(0, 1, 1);
    check("R3 transfer total", 32'(handshakes), 32'd3);

    // R4 wrap upward, page untouched
    set_cfg(16'hFFFF, 8'h03, 16'd1, 1'b0, 1'b0, 1'b0);
    step(1, 0, 1);
    step(0, 1, 1);
    check("R4 up before wrap", 32'(xfer_addr), 32'h03FFFF);
    step(0, 1, 1);
    check("R4 up after wrap", 32'(xfer_addr), 32'h030000);
    // R4 wrap downward
    set_cfg(16'h0000, 8'h03, 16'd1, 1'b1, 1'b0, 1'b0);
    step(1, 0, 1);
    step(0, 1, 1);
    check("R4 down before wrap", 32'(xfer_addr), 32'h030000);
    step(0, 1, 1);
    check("R4 down after wrap", 32'(xfer_addr), 32'h03FFFF);

    // R6 word address forming
    set_cfg(16'h8001, 8'hAB, 16'd3, 1'b0, 1'b0, 1'b1);
    step(1, 0, 1);
    step(0, 1, 1);
    check("R6 word address", 32'(xfer_addr), 32'hAB0002);
    step(0, 1, 1);
    check("R6 word next", 32'(xfer_addr), 32'hAB0004);

    // R8 auto reload: count 1, sequence repeats, stays unmasked
    set_cfg(16'h0100, 8'h02, 16'd1, 1'b0, 1'b1, 1'b0);
    step(1, 0, 1);
    handshakes = 0;
    for (int i = 0; i < 6; i++) step(0, 1, 1);
    check("R8 repeat address", 32'(xfer_addr), 32'h020101);
    check("R8 still unmasked", 32'(chan_masked), 32'd0);
    check("R9 done after reload", 32'(chan_done), 32'd1);

    // R10 stall: address held while ready low
    step(0, 1, 0);
    step(0, 1, 0);
    step(0, 1, 0);
    step(0, 0, 1);
    // R11 load and ack together
    set_cfg(16'h0040, 8'h01, 16'd0, 1'b0, 1'b0, 1'b0);
    step(1, 1, 1);
    step(0, 1, 1);
    check("R11 first after load", 32'(xfer_addr), 32'h010040);

    // constrained random
    for (int s = 0; s < 40; s++) begin
      logic [15:0] cnt;
      cnt = ($urandom % 4 == 0) ? 16'($urandom) : 16'($urandom % 8);
      set_cfg(16'($urandom), 8'($urandom), cnt, 1'($urandom), 1'($urandom), 1'($urandom));
      step(1, 1'($urandom), 1'($urandom));
      for (int c = 0; c < 60; c++) begin
        logic ld;
        ld = ($urandom % 50 == 0);
        if (ld) set_cfg(16'($urandom), 8'($urandom), 16'($urandom % 6),
                        1'($urandom), 1'($urandom), 1'($urandom));
        step(ld, ($urandom % 4 != 0), ($urandom % 3 != 0));
      end
    end
    step(0, 0, 1);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule